// File: doc/BRIEF.md
# Two-Channel Pulse-Width Modulator

This block drives two output pins, each from its own pulse-width channel. Both channels are clocked by one shared clock. Software programs the block through a simple 32-bit register port. Each channel holds two values: a period length in clocks, called the range, and a count of active clocks per period, called the duty. A 16-bit control word holds one byte per channel. That byte enables the channel, inverts its pin, sets the pin level while the channel is off, and picks one of two waveforms.

The first waveform is a contiguous pulse: the pin is active for the duty count and then inactive for the rest of the period. The second is a dithered train with the same average ratio: a running accumulator spreads the active clocks as evenly as it can across the period. Some control bits belong to functions this block does not implement (a serial shifter, a sample queue and its clear). Those bits are stored and read back, with two exceptions that always read zero, and they never change the pins.

Writes take effect at the clock edge on which they are presented. Reads are combinational from the current address. The register port has no handshake, and every access completes in one cycle.

Top module: `pwm_pair`

## Requirements
- R1: After reset, every register reads zero and both pins are low.
- R2: Channel A range is at offset 0x10 and its duty at 0x14; channel B range is at 0x20 and its duty at 0x24; the control word is at 0x00. All of these read back what was written. Offsets 0x04, 0x08 and 0x18 always read zero, and writes to them are ignored.
- R3: The control byte of channel A occupies control bits 7:0 and channel B uses bits 15:8 with the same layout. Within a byte: bit 0 enable, bit 1 serializer select, bit 2 repeat-last, bit 3 idle level, bit 4 invert, bit 5 queue select, bit 6 queue clear, bit 7 contiguous select. Bits 6 and 14 always read zero.
- R4: With bit 7 set, a period of range clocks starts with duty active clocks followed by range minus duty inactive clocks, and then repeats. The pin shows the first clock of the first period on the second rising edge after the enabling write.
- R5: With bit 7 clear, every clock adds the duty to an accumulator that starts at zero. In a clock where the sum reaches or exceeds the range, the range is subtracted from the sum and the pin is active. Each period therefore has exactly duty active clocks.
- R6: A duty equal to or greater than the range keeps the pin active for the whole period, in either waveform.
- R7: Setting bit 4 inverts the pin of an enabled channel.
- R8: A disabled channel drives its pin to the value of its idle-level bit.
- R9: The period counter and the accumulator restart when a channel's enable goes from 0 to 1 and when its range is written. A new duty value takes effect at the next period boundary.
- R10: An enabled channel with range zero holds its pin at the inactive level, which is low, or high when inverted.
- R11: Bits 1, 2 and 5 of a channel byte do not change that channel's pin waveform.
- R12: The two channels run independently: one channel's settings never affect the other channel's pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for the register port and both channels |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_o | output | 2 | Output pins, bit 0 channel A, bit 1 channel B |

## Verification
The assertions assume that the range of an enabled channel changes only through a register write, which restarts the channel. Under that assumption the period counter and the accumulator always stay below a non-zero range. They also assume the write strobe is sampled only on rising edges. The stimulus drives every write away from the edge and re-enables a channel only after first clearing its enable. For that reason each table vector begins from a fresh restart and never inherits a counter that is already out of range.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;
  localparam int NCH    = 2;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DMAC = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_QUE  = 8'h18;

  // bits 6 and 14 read as zero
  localparam logic [15:0] CTL_MASK = 16'hBFBF;

  // one control byte per channel, bit 7 down to bit 0
  typedef struct packed {
    logic ms;    // contiguous pulse select
    logic clr;   // queue clear (no function here)
    logic que;   // queue select (stored only)
    logic inv;   // invert pin
    logic idle;  // level while disabled
    logic rpt;   // repeat-last (stored only)
    logic ser;   // serializer select (stored only)
    logic en;    // channel enable
  } chan_ctl_t;

  function automatic logic [ADDR_W-1:0] rng_ofs(input int c);
    return ADDR_W'(8'h10 + 8'h10 * c);
  endfunction

  function automatic logic [ADDR_W-1:0] dat_ofs(input int c);
    return ADDR_W'(8'h14 + 8'h10 * c);
  endfunction
endpackage

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [REG_W-1:0]                 wdata_i,
  output logic [REG_W-1:0]                 rdata_o,
  output chan_ctl_t [NCH-1:0]              ctl_o,
  output logic [NCH-1:0][CNT_W-1:0]        rng_o,
  output logic [NCH-1:0][CNT_W-1:0]        dat_o,
  output logic [NCH-1:0]                   restart_o
);
  logic [15:0]                  ctl_q;
  logic [NCH-1:0][CNT_W-1:0]    rng_q;
  logic [NCH-1:0][CNT_W-1:0]    dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      rng_q <= '0;
      dat_q <= '0;
    end else if (wr_i) begin
      if (addr_i == OFS_CTRL) ctl_q <= wdata_i[15:0] & CTL_MASK;
      for (int c = 0; c < NCH; c++) begin
        if (addr_i == rng_ofs(c)) rng_q[c] <= wdata_i[CNT_W-1:0];
        if (addr_i == dat_ofs(c)) dat_q[c] <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_CTRL) rdata_o = REG_W'(ctl_q);
    for (int c = 0; c < NCH; c++) begin
      if (addr_i == rng_ofs(c)) rdata_o = REG_W'(rng_q[c]);
      if (addr_i == dat_ofs(c)) rdata_o = REG_W'(dat_q[c]);
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ctl_o[c] = chan_ctl_t'(ctl_q[8*c +: 8]);
    assign rng_o[c] = rng_q[c];
    assign dat_o[c] = dat_q[c];
    assign restart_o[c] = wr_i && ((addr_i == rng_ofs(c)) ||
                          (addr_i == OFS_CTRL && wdata_i[8*c] && !ctl_q[8*c]));
  end

  // R2
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == OFS_STAT || addr_i == OFS_DMAC || addr_i == OFS_QUE) |-> rdata_o == '0);
endmodule

// File: rtl/pwm_pair_chan.sv
module pwm_pair_chan
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chan_ctl_t        ctl_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] rng_i,
  input  logic [CNT_W-1:0] dat_i,
  output logic             pin_o
);
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, acc_q, dat_act_q;
  logic             pin_q;
  logic             wrap, rng_zero, sat, hit, raw;
  logic [SUM_W-1:0] sum;
  logic [CNT_W-1:0] acc_nxt;
  logic             unused_ctl;

  assign unused_ctl = ^{ctl_i.ser, ctl_i.rpt, ctl_i.que, ctl_i.clr};

  assign rng_zero = (rng_i == '0);
  assign wrap     = rng_zero || (cnt_q == rng_i - 1'b1);
  assign sat      = (dat_act_q >= rng_i);
  assign sum      = {1'b0, acc_q} + {1'b0, dat_act_q};
  assign hit      = sat || (sum >= {1'b0, rng_i});
  assign acc_nxt  = sat ? acc_q
                  : (hit ? CNT_W'(sum - {1'b0, rng_i}) : CNT_W'(sum));
  assign raw      = !rng_zero && (ctl_i.ms ? (cnt_q < dat_act_q) : hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      acc_q     <= '0;
      dat_act_q <= '0;
      pin_q     <= 1'b0;
    end else begin
      pin_q <= ctl_i.en ? (raw ^ ctl_i.inv) : ctl_i.idle;
      if (restart_i) begin
        cnt_q     <= '0;
        acc_q     <= '0;
        dat_act_q <= dat_i;
      end else if (ctl_i.en) begin
        if (wrap) begin
          cnt_q     <= '0;
          dat_act_q <= dat_i;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        if (!ctl_i.ms && !rng_zero) acc_q <= acc_nxt;
      end
    end
  end

  assign pin_o = pin_q;

  // R4
  cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.en && !rng_zero) |-> cnt_q < rng_i);

  // R5
  acc_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.en && !rng_zero) |-> acc_q < rng_i);

  // R8
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_i.en |=> pin_o == $past(ctl_i.idle));

  // R10
  zero_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i.en && rng_zero) |=> pin_o == $past(ctl_i.inv));

  // R9
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && !(ctl_i.en && wrap)) |=> $stable(dat_act_q));
endmodule

// File: rtl/pwm_pair.sv
module pwm_pair
  import pwm_pair_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [NCH-1:0]    pwm_o
);
  chan_ctl_t [NCH-1:0]       ctl;
  logic [NCH-1:0][CNT_W-1:0] rng, dat;
  logic [NCH-1:0]            restart;

  pwm_pair_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (bus_wr),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .rdata_o   (bus_rdata),
    .ctl_o     (ctl),
    .rng_o     (rng),
    .dat_o     (dat),
    .restart_o (restart)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    pwm_pair_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctl_i     (ctl[c]),
      .restart_i (restart[c]),
      .rng_i     (rng[c]),
      .dat_i     (dat[c]),
      .pin_o     (pwm_o[c])
    );
  end

  // R3
  ctl_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == OFS_CTRL) |-> (bus_rdata[6] == 1'b0 && bus_rdata[14] == 1'b0));
endmodule

// File: tb/pwm_pair_tb.sv
module pwm_pair_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  ctl;
    logic [15:0] dat;
    logic [15:0] rng;
    logic [7:0]  hi;     // active samples over two periods
    logic [7:0]  adj;    // adjacent active pairs over two periods
    logic        first;  // first sample after enable
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h81, 16'd2,  16'd8, 8'd4,  8'd2,  1'b1},
    '{8'h01, 16'd2,  16'd8, 8'd4,  8'd0,  1'b0},
    '{8'h01, 16'd5,  16'd8, 8'd10, 8'd4,  1'b0},
    '{8'h81, 16'd20, 16'd8, 8'd16, 8'd15, 1'b1},
    '{8'h91, 16'd2,  16'd8, 8'd12, 8'd10, 1'b0},
    '{8'hA7, 16'd3,  16'd6, 8'd6,  8'd4,  1'b1},
    '{8'h01, 16'd8,  16'd8, 8'd16, 8'd15, 1'b1},
    '{8'h81, 16'd0,  16'd4, 8'd0,  8'd0,  1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_pair u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    chk(bus_rdata == exp, req, int'(bus_rdata), int'(exp));
  endtask

  function automatic string vec_req(input int i);
    case (i)
      0: return "R4 contiguous";
      1, 2: return "R5 dithered";
      3, 6: return "R6 saturate";
      4: return "R7 invert";
      5: return "R11 ignored bits";
      default: return "R4 zero duty";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(pwm_o == 2'b00, "R1 pins after reset", int'(pwm_o), 0);
    rd_chk(8'h00, 32'h0, "R1 control after reset");
    rd_chk(8'h10, 32'h0, "R1 range after reset");

    // table of waveforms on channel A
    for (int v = 0; v < NV; v++) begin
      int hi, adj;
      logic prev, s, first;
      wr(8'h00, 32'h0);
      wr(8'h10, {16'h0, VECS[v].rng});
      wr(8'h14, {16'h0, VECS[v].dat});
      wr(8'h00, {24'h0, VECS[v].ctl});
      hi = 0; adj = 0; prev = 1'b0; first = 1'b0;
      for (int k = 0; k < 2 * int'(VECS[v].rng); k++) begin
        @(negedge clk);
        s = pwm_o[0];
        if (k == 0) first = s;
        if (s) hi++;
        if (k > 0 && s && prev) adj++;
        prev = s;
      end
      chk(hi == int'(VECS[v].hi), vec_req(v), hi, int'(VECS[v].hi));
      chk(adj == int'(VECS[v].adj), vec_req(v), adj, int'(VECS[v].adj));
      chk(first == VECS[v].first, vec_req(v), int'(first), int'(VECS[v].first));
      chk(pwm_o[1] == 1'b0, "R12 channel B untouched", int'(pwm_o[1]), 0);
    end

    // R2 register map and readback
    wr(8'h00, 32'h0);
    wr(8'h24, 32'h0000_1234);
    rd_chk(8'h24, 32'h0000_1234, "R2 duty B readback");
    wr(8'h04, 32'hFFFF_FFFF);
    rd_chk(8'h04, 32'h0, "R2 status reads zero");
    wr(8'h18, 32'hFFFF_FFFF);
    rd_chk(8'h18, 32'h0, "R2 queue reads zero");
    // R3 control bits 6 and 14 read zero
    wr(8'h00, 32'h0000_FFFF);
    rd_chk(8'h00, 32'h0000_BFBF, "R3 control readback");
    wr(8'h00, 32'h0);

    // R8 idle level on A while B runs contiguous 3 of 5 (R12)
    begin
      int hb;
      logic fb;
      wr(8'h20, 32'd5);
      wr(8'h24, 32'd3);
      wr(8'h00, 32'h0000_8108);
      hb = 0; fb = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(negedge clk);
        if (k == 0) fb = pwm_o[1];
        if (pwm_o[1]) hb++;
        if (k == 9) chk(pwm_o[0] == 1'b1, "R8 idle level high", int'(pwm_o[0]), 1);
      end
      chk(hb == 6, "R12 channel B count", hb, 6);
      chk(fb == 1'b1, "R12 channel B first", int'(fb), 1);
    end

    // R10 zero range
    wr(8'h00, 32'h0);
    wr(8'h10, 32'd0);
    wr(8'h14, 32'd3);
    wr(8'h00, 32'h0000_0081);
    repeat (4) @(negedge clk);
    chk(pwm_o[0] == 1'b0, "R10 zero range low", int'(pwm_o[0]), 0);
    wr(8'h00, 32'h0000_0091);
    repeat (2) @(negedge clk);
    chk(pwm_o[0] == 1'b1, "R10 zero range inverted", int'(pwm_o[0]), 1);

    // R9 new duty waits for the period boundary
    begin
      logic [15:0] smp;
      wr(8'h00, 32'h0);
      wr(8'h10, 32'd8);
      wr(8'h14, 32'd2);
      wr(8'h00, 32'h0000_0081);
      for (int k = 0; k < 16; k++) begin
        @(negedge clk);
        smp[k] = pwm_o[0];
        if (k == 3) begin bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'd6; end
        if (k == 4) bus_wr = 1'b0;
      end
      chk(smp[7:4] == 4'b0000, "R9 old duty holds", int'(smp[7:4]), 0);
      chk(smp[15:8] == 8'b0011_1111, "R9 new duty next period", int'(smp[15:8]), 8'h3F);
    end

    // R9 range write restarts the period
    begin
      logic [7:0] smp;
      wr(8'h00, 32'h0);
      wr(8'h14, 32'd2);
      wr(8'h00, 32'h0000_0081);
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        smp[k] = pwm_o[0];
        if (k == 4) begin bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'd8; end
        if (k == 5) bus_wr = 1'b0;
      end
      chk(smp[7:5] == 3'b110, "R9 range write restart", int'(smp[7:5]), 6);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule